// File: doc/BRIEF.md
# Address-Tagged Sector Store with Read Verification

This block keeps a small logical-to-physical map and a page store behind it. A host writes a sector by issuing a command that carries the logical block address (LBA), and then streams the sector's words. The block places the sector in the next free physical page, records the host LBA beside the data as a tag, and points the map entry for that LBA at the page. Pages are handed out in strict sequence from a free pointer that wraps around. There is no reclamation. A page that is reused therefore silently takes over from whatever an older map entry still points at.

A read command carries only an LBA. The block looks up the map entry and checks its parity. It then fetches the tag stored with the target page and compares it with the requested LBA. Only when all three checks pass does the sector stream back. Otherwise a single status beat reports what went wrong. Host sectors are 512 bytes in a full build; the default parameters shrink the sector to 16 words so that the page memory stays small. A debug input can invert one bit of a map entry or of a stored tag, so that both error paths can be exercised.

Both data-bearing channels use valid/ready handshakes. A beat moves only on a cycle where valid and ready are both high. The block holds its response beat unchanged for as long as the consumer keeps ready low. The write-data stream may pause at any point by dropping valid. Commands are accepted one at a time, and only while the block is idle.

Top module: `lba_tag_store`

## Requirements
- R1: After reset, both command channels are ready, no response is pending, write data is not accepted, and every map entry reads as unmapped.
- R2: A write command is followed by exactly WORDS data beats. When the final beat is taken, the sector and its LBA tag land in the page named by the free pointer, the map entry for that LBA points at this page, and the pointer advances by one, wrapping after the last page.
- R3: A read of a correctly mapped LBA returns WORDS beats, in the order they were written, each with status 0, and rsp_last high only on the final beat.
- R4: A read of an unmapped LBA returns one beat with status 1, data zero and rsp_last high.
- R5: When the tag stored in the looked-up page differs from the requested LBA, the read returns one beat with status 2, data zero and rsp_last high. This happens after wrap-around reuses the page, or after a tag has been corrupted.
- R6: A map entry is {parity bit 7, valid bit 6, page bits 5:0}, with even parity over all eight bits. An entry whose parity fails yields one beat with status 3, data zero and rsp_last high. This takes precedence over both the unmapped and the tag-mismatch outcomes.
- R7: A one-cycle pulse on dbg_flip inverts bit dbg_bit of map entry dbg_index when dbg_target is 0, or of the tag of page dbg_index when dbg_target is 1. Tag bits 6 and 7 do not exist, so a flip aimed at them has no effect. A second identical flip restores the bit. A flip in the cycle a write completes is dropped.
- R8: While rsp_valid is high and rsp_ready is low, rsp_data, rsp_status and rsp_last hold their values into the next cycle.
- R9: No command is accepted while a write or a response is in progress. When both command channels are valid in the idle state, the write wins and rd_cmd_ready is low.
- R10: Rewriting an LBA moves its mapping to a newly allocated page, and later reads return the newest data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_cmd_valid | input | 1 | Write command offered |
| wr_cmd_ready | output | 1 | Write command accepted this cycle if valid |
| wr_cmd_lba | input | LBA_W | LBA of the sector to write |
| wr_data_valid | input | 1 | Write data beat offered |
| wr_data_ready | output | 1 | Block is taking write data |
| wr_data | input | DATA_W | Write data word |
| rd_cmd_valid | input | 1 | Read command offered |
| rd_cmd_ready | output | 1 | Read command accepted this cycle if valid |
| rd_cmd_lba | input | LBA_W | LBA to read |
| rsp_valid | output | 1 | Response beat present |
| rsp_ready | input | 1 | Consumer takes the response beat |
| rsp_data | output | DATA_W | Sector word, zero on status-only beats |
| rsp_status | output | 2 | 0 ok, 1 unmapped, 2 tag mismatch, 3 map parity error |
| rsp_last | output | 1 | Final beat of the response |
| dbg_flip | input | 1 | Invert one selected bit |
| dbg_target | input | 1 | 0 map entry, 1 page tag |
| dbg_index | input | IDX_W | Map entry or page number |
| dbg_bit | input | BIT_W | Bit position to invert |

## Verification
On every cycle, the assertions check the response-channel rules: held beats stay stable under back-pressure, error beats are single zero-data final beats, write wins over read at the command port, and no command is taken while the block is busy. Only the bench's scenarios can show that the right status comes out. That covers a page that is reused after the free pointer wraps, the precedence of a parity fault over unmapped and mismatch outcomes, and a flip aimed at a nonexistent tag bit. The bench also checks that streamed data matches what was last written to each LBA across a random mix of writes, reads and injected faults.

// File: rtl/lts_pkg.sv
package lts_pkg;
  typedef enum logic [1:0] {
    ST_OK       = 2'd0,
    ST_UNMAPPED = 2'd1,
    ST_TAG_ERR  = 2'd2,
    ST_PAR_ERR  = 2'd3
  } rd_status_e;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_WDATA = 2'd1,
    S_RDATA = 2'd2,
    S_RSTAT = 2'd3
  } ctrl_state_e;
endpackage

// File: rtl/lts_l2p_table.sv
module lts_l2p_table #(
  parameter int LBA_W  = 6,
  parameter int PAGE_W = 6,
  parameter int BIT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LBA_W-1:0]  look_lba,
  output logic              look_valid,
  output logic [PAGE_W-1:0] look_page,
  output logic              look_par_ok,
  input  logic              upd_en,
  input  logic [LBA_W-1:0]  upd_lba,
  input  logic [PAGE_W-1:0] upd_page,
  input  logic              flip_en,
  input  logic [LBA_W-1:0]  flip_lba,
  input  logic [BIT_W-1:0]  flip_bit
);
  localparam int ENTRIES = 1 << LBA_W;
  localparam int ENT_W   = PAGE_W + 2;

  // entry layout: {parity, valid, page}; even parity over the whole entry
  logic [ENT_W-1:0] tbl [ENTRIES];
  logic [ENT_W-1:0] ent;

  assign ent         = tbl[look_lba];
  assign look_page   = ent[PAGE_W-1:0];
  assign look_valid  = ent[PAGE_W];
  assign look_par_ok = ~(^ent);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) tbl[i] <= '0;
    end else if (upd_en) begin
      tbl[upd_lba] <= {^{1'b1, upd_page}, 1'b1, upd_page};
    end else if (flip_en && (int'(flip_bit) < ENT_W)) begin
      tbl[flip_lba][flip_bit] <= ~tbl[flip_lba][flip_bit];
    end
  end
endmodule

// File: rtl/lts_page_store.sv
module lts_page_store #(
  parameter int LBA_W  = 6,
  parameter int PAGE_W = 6,
  parameter int WORDS  = 16,
  parameter int DATA_W = 32,
  parameter int BIT_W  = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [PAGE_W-1:0]          acc_page,
  input  logic [$clog2(WORDS)-1:0]   acc_word,
  input  logic [DATA_W-1:0]          wr_data,
  output logic [DATA_W-1:0]          rd_data,
  input  logic                       tag_wr,
  input  logic [LBA_W-1:0]           tag_wval,
  input  logic [PAGE_W-1:0]          tag_rpage,
  output logic [LBA_W-1:0]           tag_rval,
  input  logic                       flip_en,
  input  logic [PAGE_W-1:0]          flip_page,
  input  logic [BIT_W-1:0]           flip_bit
);
  localparam int PAGES  = 1 << PAGE_W;
  localparam int WORD_W = $clog2(WORDS);
  localparam int DEPTH  = PAGES * WORDS;

  logic [DATA_W-1:0]        mem [DEPTH];
  logic [LBA_W-1:0]         tag [PAGES];
  logic [PAGE_W+WORD_W-1:0] addr;

  // WORDS is a power of two, so page and word concatenate into the address
  assign addr     = {acc_page, acc_word};
  assign rd_data  = mem[addr];
  assign tag_rval = tag[tag_rpage];

  always_ff @(posedge clk) begin
    if (wr_en) mem[addr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PAGES; i++) tag[i] <= '0;
    end else if (tag_wr) begin
      tag[acc_page] <= tag_wval;
    end else if (flip_en && (int'(flip_bit) < LBA_W)) begin
      tag[flip_page][flip_bit] <= ~tag[flip_page][flip_bit];
    end
  end
endmodule

// File: rtl/lts_ctrl.sv
module lts_ctrl
  import lts_pkg::*;
#(
  parameter int LBA_W  = 6,
  parameter int PAGE_W = 6,
  parameter int WORDS  = 16,
  parameter int DATA_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_cmd_valid,
  output logic                     wr_cmd_ready,
  input  logic [LBA_W-1:0]         wr_cmd_lba,
  input  logic                     wr_data_valid,
  output logic                     wr_data_ready,
  input  logic                     rd_cmd_valid,
  output logic                     rd_cmd_ready,
  input  logic [LBA_W-1:0]         rd_cmd_lba,
  output logic                     rsp_valid,
  input  logic                     rsp_ready,
  output logic [DATA_W-1:0]        rsp_data,
  output logic [1:0]               rsp_status,
  output logic                     rsp_last,
  input  logic                     look_valid,
  input  logic [PAGE_W-1:0]        look_page,
  input  logic                     look_par_ok,
  input  logic [LBA_W-1:0]         tag_rval,
  output logic                     upd_en,
  output logic [LBA_W-1:0]         upd_lba,
  output logic [PAGE_W-1:0]        upd_page,
  output logic                     st_wr_en,
  output logic [PAGE_W-1:0]        acc_page,
  output logic [$clog2(WORDS)-1:0] acc_word,
  input  logic [DATA_W-1:0]        st_rd_data
);
  localparam int WORD_W = $clog2(WORDS);
  localparam logic [WORD_W-1:0] LAST_W = WORD_W'(WORDS - 1);

  ctrl_state_e       state;
  logic [WORD_W-1:0] cnt;
  logic [PAGE_W-1:0] cur_page;
  logic [PAGE_W-1:0] free_ptr;
  logic [LBA_W-1:0]  cur_lba;
  rd_status_e        stat_q;
  rd_status_e        chk;
  logic              at_last;

  // parity first, then the valid bit, then the tag comparison
  always_comb begin
    if (!look_par_ok)             chk = ST_PAR_ERR;
    else if (!look_valid)         chk = ST_UNMAPPED;
    else if (tag_rval != rd_cmd_lba) chk = ST_TAG_ERR;
    else                          chk = ST_OK;
  end

  assign at_last       = (cnt == LAST_W);
  assign wr_cmd_ready  = (state == S_IDLE);
  assign rd_cmd_ready  = (state == S_IDLE) && !wr_cmd_valid;
  assign wr_data_ready = (state == S_WDATA);
  assign rsp_valid     = (state == S_RDATA) || (state == S_RSTAT);
  assign rsp_data      = (state == S_RDATA) ? st_rd_data : '0;
  assign rsp_status    = stat_q;
  assign rsp_last      = (state == S_RSTAT) || ((state == S_RDATA) && at_last);
  assign st_wr_en      = (state == S_WDATA) && wr_data_valid;
  assign upd_en        = st_wr_en && at_last;
  assign upd_lba       = cur_lba;
  assign upd_page      = cur_page;
  assign acc_page      = cur_page;
  assign acc_word      = cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cnt      <= '0;
      cur_page <= '0;
      free_ptr <= '0;
      cur_lba  <= '0;
      stat_q   <= ST_OK;
    end else begin
      unique case (state)
        S_IDLE: begin
          cnt <= '0;
          if (wr_cmd_valid) begin
            cur_page <= free_ptr;
            cur_lba  <= wr_cmd_lba;
            stat_q   <= ST_OK;
            state    <= S_WDATA;
          end else if (rd_cmd_valid) begin
            cur_page <= look_page;
            stat_q   <= chk;
            state    <= (chk == ST_OK) ? S_RDATA : S_RSTAT;
          end
        end
        S_WDATA: if (wr_data_valid) begin
          cnt <= cnt + 1'b1;
          if (at_last) begin
            free_ptr <= free_ptr + 1'b1;
            state    <= S_IDLE;
          end
        end
        S_RDATA: if (rsp_ready) begin
          cnt <= cnt + 1'b1;
          if (at_last) state <= S_IDLE;
        end
        S_RSTAT: if (rsp_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lba_tag_store.sv
module lba_tag_store #(
  parameter int LBA_W  = 6,
  parameter int PAGE_W = 6,
  parameter int WORDS  = 16,
  parameter int DATA_W = 32,
  localparam int IDX_W = (LBA_W > PAGE_W) ? LBA_W : PAGE_W,
  localparam int ENT_W = PAGE_W + 2,
  localparam int BIT_W = $clog2((ENT_W > LBA_W) ? ENT_W : LBA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_cmd_valid,
  output logic              wr_cmd_ready,
  input  logic [LBA_W-1:0]  wr_cmd_lba,
  input  logic              wr_data_valid,
  output logic              wr_data_ready,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_cmd_valid,
  output logic              rd_cmd_ready,
  input  logic [LBA_W-1:0]  rd_cmd_lba,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic [1:0]        rsp_status,
  output logic              rsp_last,
  input  logic              dbg_flip,
  input  logic              dbg_target,
  input  logic [IDX_W-1:0]  dbg_index,
  input  logic [BIT_W-1:0]  dbg_bit
);
  localparam int WORD_W = $clog2(WORDS);

  logic              look_valid, look_par_ok, upd_en, st_wr_en;
  logic [PAGE_W-1:0] look_page, upd_page, acc_page;
  logic [LBA_W-1:0]  upd_lba, tag_rval;
  logic [WORD_W-1:0] acc_word;
  logic [DATA_W-1:0] st_rd_data;

  lts_l2p_table #(.LBA_W(LBA_W), .PAGE_W(PAGE_W), .BIT_W(BIT_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .look_lba(rd_cmd_lba), .look_valid(look_valid), .look_page(look_page),
    .look_par_ok(look_par_ok),
    .upd_en(upd_en), .upd_lba(upd_lba), .upd_page(upd_page),
    .flip_en(dbg_flip && !dbg_target), .flip_lba(dbg_index[LBA_W-1:0]),
    .flip_bit(dbg_bit)
  );

  lts_page_store #(.LBA_W(LBA_W), .PAGE_W(PAGE_W), .WORDS(WORDS),
                   .DATA_W(DATA_W), .BIT_W(BIT_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(st_wr_en), .acc_page(acc_page), .acc_word(acc_word),
    .wr_data(wr_data), .rd_data(st_rd_data),
    .tag_wr(upd_en), .tag_wval(upd_lba),
    .tag_rpage(look_page), .tag_rval(tag_rval),
    .flip_en(dbg_flip && dbg_target), .flip_page(dbg_index[PAGE_W-1:0]),
    .flip_bit(dbg_bit)
  );

  lts_ctrl #(.LBA_W(LBA_W), .PAGE_W(PAGE_W), .WORDS(WORDS), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .wr_cmd_valid(wr_cmd_valid), .wr_cmd_ready(wr_cmd_ready), .wr_cmd_lba(wr_cmd_lba),
    .wr_data_valid(wr_data_valid), .wr_data_ready(wr_data_ready),
    .rd_cmd_valid(rd_cmd_valid), .rd_cmd_ready(rd_cmd_ready), .rd_cmd_lba(rd_cmd_lba),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rsp_status(rsp_status), .rsp_last(rsp_last),
    .look_valid(look_valid), .look_page(look_page), .look_par_ok(look_par_ok),
    .tag_rval(tag_rval),
    .upd_en(upd_en), .upd_lba(upd_lba), .upd_page(upd_page),
    .st_wr_en(st_wr_en), .acc_page(acc_page), .acc_word(acc_word),
    .st_rd_data(st_rd_data)
  );
endmodule

// File: rtl/lts_chk.sv
module lts_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_cmd_valid,
  input logic              wr_cmd_ready,
  input logic              wr_data_ready,
  input logic              rd_cmd_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_data,
  input logic [1:0]        rsp_status,
  input logic              rsp_last
);
  // R8
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data)
                                && $stable(rsp_status) && $stable(rsp_last));

  // R4 R5 R6
  err_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && (rsp_status != 2'd0) |-> rsp_last && (rsp_data == '0));

  // R9
  wr_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cmd_ready |-> !wr_cmd_valid);

  // R9
  busy_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !wr_cmd_ready && !rd_cmd_ready);

  // R2
  wdata_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data_ready |-> !wr_cmd_ready && !rsp_valid);

  // R3
  end_of_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_ready && rsp_last |=> !rsp_valid);
endmodule

bind lba_tag_store lts_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/lba_tag_store_bench.sv
module lba_tag_store_bench;
  localparam int LBA_W = 6, PAGE_W = 6, WORDS = 16, DATA_W = 32;
  localparam int NLBA = 1 << LBA_W, NPG = 1 << PAGE_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_cmd_valid = 0, wr_data_valid = 0, rd_cmd_valid = 0, rsp_ready = 0;
  logic [LBA_W-1:0] wr_cmd_lba = '0, rd_cmd_lba = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic dbg_flip = 0, dbg_target = 0;
  logic [5:0] dbg_index = '0;
  logic [2:0] dbg_bit = '0;
  logic wr_cmd_ready, wr_data_ready, rd_cmd_ready, rsp_valid, rsp_last;
  logic [DATA_W-1:0] rsp_data;
  logic [1:0] rsp_status;

  always #10 clk = ~clk;

  lba_tag_store u_lba_tag_store (.*);

  int checks = 0, failures = 0;
  bit done = 0;

  // bench model of the block's visible state
  bit          m_valid [NLBA];
  bit          m_bad   [NLBA];
  int          m_page  [NLBA];
  logic [5:0]  m_tag   [NPG];
  int unsigned m_seed  [NPG];
  int          fp = 0;

  function automatic logic [31:0] wordv(int unsigned seed, int i);
    return (seed * 32'h9E3779B1) + (i * 32'h01000193) ^ 32'h5A5A0000;
  endfunction

  function automatic int exp_status(int lba);
    if (m_bad[lba]) return 3;
    if (!m_valid[lba]) return 1;
    if (m_tag[m_page[lba]] != 6'(lba)) return 2;
    return 0;
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_write(int lba);
    int unsigned seed = $urandom;
    @(negedge clk);
    wr_cmd_valid = 1; wr_cmd_lba = 6'(lba);
    while (!wr_cmd_ready) @(negedge clk);
    @(negedge clk);
    wr_cmd_valid = 0;
    for (int i = 0; i < WORDS; i++) begin
      if ($urandom % 3 == 0) begin wr_data_valid = 0; @(negedge clk); end
      wr_data_valid = 1; wr_data = wordv(seed, i);
      @(negedge clk);
    end
    wr_data_valid = 0;
    m_seed[fp] = seed; m_tag[fp] = 6'(lba);
    m_valid[lba] = 1; m_bad[lba] = 0; m_page[lba] = fp;
    fp = (fp + 1) % NPG;
  endtask

  // tgt 0: map entry {par,valid,page}; tgt 1: page tag
  task automatic do_flip(bit tgt, int idx, int b);
    @(negedge clk);
    dbg_flip = 1; dbg_target = tgt; dbg_index = 6'(idx); dbg_bit = 3'(b);
    @(negedge clk);
    dbg_flip = 0;
    if (tgt) begin
      if (b < 6) m_tag[idx][b] = ~m_tag[idx][b];
    end else begin
      m_bad[idx] = ~m_bad[idx];
      if (b == 6) m_valid[idx] = ~m_valid[idx];
      else if (b < 6) m_page[idx] = m_page[idx] ^ (1 << b);
    end
  endtask

  task automatic do_read(int lba, string req);
    int es, st, n, bad_data;
    logic [31:0] got [WORDS];
    bit fin;
    es = exp_status(lba);
    @(negedge clk);
    rd_cmd_valid = 1; rd_cmd_lba = 6'(lba);
    while (!rd_cmd_ready) @(negedge clk);
    @(negedge clk);
    rd_cmd_valid = 0;
    n = 0; st = -1; fin = 0; bad_data = 0;
    for (int g = 0; g < 200 && !fin; g++) begin
      rsp_ready = ($urandom % 4) != 0;   // R8 random back-pressure
      if (rsp_valid && rsp_ready) begin
        if (n == 0) st = int'(rsp_status);
        else if (int'(rsp_status) != st) bad_data++;
        if (n < WORDS) got[n] = rsp_data;
        if (es != 0 && rsp_data != 0) bad_data++;
        n++;
        fin = rsp_last;
      end
      @(negedge clk);
    end
    rsp_ready = 0;
    chk(st == es, {req, " status"}, st, es);
    if (es == 0) begin
      chk(n == WORDS, {req, " R3 beat count"}, n, WORDS);
      for (int i = 0; i < WORDS && i < n; i++)
        if (got[i] != wordv(m_seed[m_page[lba]], i)) bad_data++;
      chk(bad_data == 0, {req, " R3 data"}, bad_data, 0);
    end else begin
      chk(n == 1 && bad_data == 0, {req, " single zero beat"}, n, 1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < NLBA; i++) begin m_valid[i] = 0; m_bad[i] = 0; m_page[i] = 0; end
    for (int i = 0; i < NPG; i++) begin m_tag[i] = '0; m_seed[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk(wr_cmd_ready && rd_cmd_ready && !rsp_valid && !wr_data_ready, "R1 reset ports",
        {wr_cmd_ready, rd_cmd_ready, rsp_valid, wr_data_ready}, 4'b1100);
    do_read(5, "R1 R4 unmapped after reset");
    // R9 write wins when both commands are offered
    wr_cmd_valid = 1; rd_cmd_valid = 1; #1;
    chk(!rd_cmd_ready && wr_cmd_ready, "R9 write priority", rd_cmd_ready, 0);
    wr_cmd_valid = 0; rd_cmd_valid = 0;
    do_write(5);
    do_read(5, "R2 R3 write then read");
    do_write(5);
    do_read(5, "R10 rewrite");
    do_flip(1, m_page[5], 2);
    do_read(5, "R5 R7 tag flipped");
    do_flip(1, m_page[5], 2);
    do_read(5, "R7 tag restored");
    do_flip(1, m_page[5], 7);
    do_read(5, "R7 tag bit 7 ignored");
    do_flip(0, 5, 3);
    do_flip(1, 1, 0);
    do_read(5, "R6 parity over tag");
    do_flip(0, 5, 3);
    do_flip(1, 1, 0);
    do_read(5, "R6 R7 entry restored");
    do_flip(0, 9, 7);
    do_read(9, "R6 parity over unmapped");
    do_flip(0, 9, 7);
    do_read(9, "R4 unmapped again");
    // R5 page reuse after the free pointer wraps
    do_write(20);
    for (int i = 0; i < NPG; i++) do_write(21);
    do_read(20, "R5 wrap reuse");
    do_read(21, "R2 R3 after wrap");
    // random mix
    for (int k = 0; k < 300; k++) begin
      int op = $urandom % 10;
      int l = $urandom % NLBA;
      if (op < 4) do_write(l);
      else if (op < 8) do_read(l, "R3 R4 R5 R6 random read");
      else if (op == 8) do_flip(1, $urandom % NPG, $urandom % 8);
      else do_flip(0, l, 7);
    end
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule